// File: doc/BRIEF.md
# DAC Sample Playback Sequencer

This block streams 16-bit samples from a small write buffer to a DAC code output at a programmable pace. Software fills the buffer through a word-wide register port, picks what starts playback (buffer data present, an external strobe, or a software command) and how playback ends (free-running, a single sample, or a counted burst). A rate timer paces the output. Each accepted sample appears on the code output with a one-cycle update strobe, either as plain binary or converted to Gray code.

Three status flags report the buffer fill against two software thresholds. An interrupt register latches completion, underflow and almost-empty events. A soft reset drains the buffer and stops playback without touching the rest of the configuration. A 3-bit interpolation setting is kept for software but has no effect on the output.

Top module: `dac_playback_seq`

## Requirements
- R1: After reset, the control register (address 0) reads 0x000000C0. The rate (1), interrupt (2) and level (3) registers read 0. The code output, the strobe and the interrupt output are all low.
- R2: A write to address 3 pushes the low 16 bits into the buffer of DEPTH entries. A read of address 3 returns the fill level. A push while the buffer is full is ignored, and samples leave in the order they were written.
- R3: Control bit 6 reads high when the level is 0. Bit 7 reads high when the level is at or below the threshold in bits 3:0. Bit 5 reads high when the level exceeds the threshold in bits 15:12.
- R4: The start field (control bits 17:16) selects the trigger that starts an idle sequencer:
  - 0: a non-empty buffer;
  - 1: a high `ext_start` sampled at a clock edge;
  - 2: a control write with bit 20 set, judged against the start field already stored;
  - 3: never starts.
- R5: Let P be the rate count (rate register bits 15:0), with a count of 0 taken as 1. The first sample tick comes P clock edges after the start edge, and later ticks follow every P edges. The strobe is high in the cycle after a tick that took a sample.
- R6: Play mode (control bits 25:24) 0, and the reserved value 2, send one sample per tick without end.
- R7: Play mode 1 sends one sample at the first tick, then sets the done flag and returns to idle.
- R8: Play mode 3 runs for N ticks, where N is the sample count in rate bits 31:16 and a count of 0 is taken as 1. It then sets the done flag and returns to idle. Ticks that find the buffer empty also count toward N.
- R9: When control bit 19 is 0, the code is the sample XOR (sample >> 1). When bit 19 is 1, the code is the sample unchanged.
- R10: A tick that finds the buffer empty sets the underflow flag, keeps the previous code and gives no strobe.
- R11: The interrupt register holds flags and enables:
  - bit 0: done flag;
  - bit 1: underflow flag;
  - bit 2: almost-empty flag, set when bit 7 of the control register goes from low to high;
  - bit 16: done enable;
  - bit 17: underflow enable.
  
  Writing 1 to a flag bit clears it. `irq` is high while an enabled done or underflow flag is set.
- R12: Control bit 18 reads high while playback runs. A control write with bit 31 set empties the buffer and stops playback.
- R13: Control bits 10:8 are stored and read back, and have no effect on playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 control, 1 rate, 2 interrupt, 3 buffer) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| ext_start | input | 1 | External start strobe |
| dac_code | output | 16 | DAC code, held between updates |
| dac_strobe | output | 1 | One-cycle pulse after each code update |
| irq | output | 1 | Interrupt request |

## Verification
The first code of a triggered run is due exactly P edges after the edge that accepted the start, and each later code is due P edges after the one before it. The bench counts posedges, records the edge count of every strobe seen at the following falling edge, and compares the recorded differences with P. Register reads are combinational, so status, level and flags are sampled one step after the falling edge that follows the write edge that changed them. Flag and activity checks wait out a margin of whole rate periods beyond the last expected tick before they sample.

// File: rtl/dac_playback_seq.sv
module dac_playback_seq #(
  parameter int DEPTH = 16,
  parameter int DW    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ext_start,
  output logic [DW-1:0] dac_code,
  output logic        dac_strobe,
  output logic        irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [3:0]  ae_thr, af_thr;
  logic [2:0]  interp;
  logic [1:0]  smode, omode;
  logic        gray_byp;
  logic [15:0] rate_cnt, samp_cnt;
  logic        f_done, f_uf, f_ae, en_done, en_uf;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic        active, ae_prev;
  logic [15:0] timer, remain;

  wire wr_ctrl  = reg_we && reg_addr == 2'd0;
  wire wr_rate  = reg_we && reg_addr == 2'd1;
  wire wr_int   = reg_we && reg_addr == 2'd2;
  wire wr_fifo  = reg_we && reg_addr == 2'd3;
  wire soft_rst = wr_ctrl && reg_wdata[31];
  wire cpu_go   = wr_ctrl && reg_wdata[20];

  wire empty    = count == '0;
  wire full     = count == CW'(DEPTH);
  wire ae_now   = count <= CW'(ae_thr);
  wire af_now   = count >  CW'(af_thr);

  wire push     = wr_fifo && !full;
  wire tick     = active && timer == '0 && !soft_rst;
  wire pop      = tick && !empty;
  wire underrun = tick && empty;
  wire last     = tick && (omode == 2'd1 || (omode == 2'd3 && remain <= 16'd1));
  wire start_ok = !active && !soft_rst &&
                  ((smode == 2'd0 && !empty) ||
                   (smode == 2'd1 && ext_start) ||
                   (smode == 2'd2 && cpu_go));
  wire [15:0] period_m1 = (rate_cnt == '0) ? 16'd0 : rate_cnt - 16'd1;

  wire [DW-1:0] head      = mem[rptr];
  wire [DW-1:0] code_next = gray_byp ? head : (head ^ (head >> 1));

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_thr <= '0; af_thr <= '0; interp <= '0; smode <= '0;
      omode <= '0; gray_byp <= 1'b0; rate_cnt <= '0; samp_cnt <= '0;
      en_done <= 1'b0; en_uf <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ae_thr   <= reg_wdata[3:0];
        interp   <= reg_wdata[10:8];
        af_thr   <= reg_wdata[15:12];
        smode    <= reg_wdata[17:16];
        gray_byp <= reg_wdata[19];
        omode    <= reg_wdata[25:24];
      end
      if (wr_rate) begin
        rate_cnt <= reg_wdata[15:0];
        samp_cnt <= reg_wdata[31:16];
      end
      if (wr_int) begin
        en_done <= reg_wdata[16];
        en_uf   <= reg_wdata[17];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_done <= 1'b0; f_uf <= 1'b0; f_ae <= 1'b0; ae_prev <= 1'b1;
    end else begin
      ae_prev <= ae_now;
      f_done  <= (f_done & ~(wr_int & reg_wdata[0])) | last;
      f_uf    <= (f_uf   & ~(wr_int & reg_wdata[1])) | underrun;
      f_ae    <= (f_ae   & ~(wr_int & reg_wdata[2])) | (ae_now & ~ae_prev);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= reg_wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else if (soft_rst) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push) wptr <= inc_ptr(wptr);
      if (pop)  rptr <= inc_ptr(rptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; timer <= '0; remain <= '0;
    end else if (soft_rst) begin
      active <= 1'b0;
    end else if (start_ok) begin
      active <= 1'b1;
      timer  <= period_m1;
      remain <= (samp_cnt == '0) ? 16'd1 : samp_cnt;
    end else if (tick) begin
      if (last) active <= 1'b0;
      timer  <= period_m1;
      remain <= remain - 16'd1;
    end else if (active) begin
      timer <= timer - 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code <= '0; dac_strobe <= 1'b0;
    end else begin
      dac_strobe <= pop;
      if (pop) dac_code <= code_next;
    end
  end

  assign irq = (f_done & en_done) | (f_uf & en_uf);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[3:0]   = ae_thr;
        reg_rdata[5]     = af_now;
        reg_rdata[6]     = empty;
        reg_rdata[7]     = ae_now;
        reg_rdata[10:8]  = interp;
        reg_rdata[15:12] = af_thr;
        reg_rdata[17:16] = smode;
        reg_rdata[18]    = active;
        reg_rdata[19]    = gray_byp;
        reg_rdata[25:24] = omode;
      end
      2'd1: reg_rdata = {samp_cnt, rate_cnt};
      2'd2: begin
        reg_rdata[0]  = f_done;
        reg_rdata[1]  = f_uf;
        reg_rdata[2]  = f_ae;
        reg_rdata[16] = en_done;
        reg_rdata[17] = en_uf;
      end
      default: reg_rdata = 32'(count);
    endcase
  end
endmodule

// File: rtl/dac_playback_seq_chk.sv
module dac_playback_seq_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [DW-1:0] dac_code,
  input logic          dac_strobe,
  input logic          irq,
  input logic          active,
  input logic [CW-1:0] count,
  input logic          f_done,
  input logic          f_uf
);
  p_fifo_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_strobe_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |-> $past(active));

  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_strobe |-> $stable(dac_code));

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (f_done || f_uf));

  p_softrst_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == 2'd0 && reg_wdata[31]) |-> (count == '0 && !active));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_done) |-> !active);
endmodule

bind dac_playback_seq dac_playback_seq_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dac_code(dac_code), .dac_strobe(dac_strobe),
  .irq(irq), .active(active), .count(count), .f_done(f_done), .f_uf(f_uf)
);

// File: tb/dac_playback_seq_test.sv
`timescale 1ns/1ps
module dac_playback_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, ext_start = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] dac_code;
  logic dac_strobe, irq;

  dac_playback_seq uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_start(ext_start),
    .dac_code(dac_code), .dac_strobe(dac_strobe), .irq(irq));

  always #5 clk = ~clk;

  int cyc = 0, nvec = 0, nfail = 0, ncap = 0;
  bit finished = 0;
  logic [15:0] sq [0:63];
  logic [15:0] cap_code [0:63];
  int cap_cyc [0:63];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && dac_strobe && ncap < 64) begin
    cap_code[ncap] = dac_code; cap_cyc[ncap] = cyc; ncap = ncap + 1;
  end

  function automatic logic [15:0] gray(input logic [15:0] x);
    return x ^ (x >> 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_start = 1'b1;
    @(negedge clk); ext_start = 1'b0;
  endtask

  task automatic play(input int om, input int sm, input bit byp, input int rate,
                      input int k, input int samp, input int aet, input int aft, input int ip);
    logic [31:0] ctl, v;
    int p, n_exp, ticks, t0;
    bit uf_exp, done_exp, ae_exp;
    p = (rate == 0) ? 1 : rate;
    ticks = (samp == 0) ? 1 : samp;
    ctl = (32'(aet) & 32'hF) | ((32'(aft) & 32'hF) << 12) | ((32'(ip) & 32'h7) << 8) |
          (32'(sm) << 16) | (32'(byp) << 19) | (32'(om) << 24);
    wr(0, ctl | 32'h8000_0000);
    wr(2, 32'h0003_0007);
    wr(1, {samp[15:0], rate[15:0]});
    ncap = 0;
    for (int i = 0; i < k; i++) begin
      sq[i] = 16'($urandom);
      wr(3, {16'h0, sq[i]});
    end
    t0 = cyc;
    if (sm == 2) begin wr(0, ctl | 32'h0010_0000); t0 = cyc; end
    if (sm == 1) begin pulse_ext(); t0 = cyc; end
    if (sm != 0) begin rd(0, v); chk(v[18] == 1'b1, "R12 active during run", v[18], 1); end
    repeat (p * ((k > ticks ? k : ticks) + 3) + 10) @(negedge clk);
    if (om == 1) n_exp = 1;
    else if (om == 3) n_exp = (ticks < k) ? ticks : k;
    else n_exp = k;
    uf_exp   = (om == 0 || om == 2) || (om == 3 && ticks > k);
    done_exp = (om == 1 || om == 3);
    ae_exp   = (k > aet) && (k - n_exp <= aet);
    chk(ncap == n_exp, (om == 1) ? "R7 sample count" : (om == 3) ? "R8 sample count" : "R6 sample count", ncap, n_exp);
    for (int i = 0; i < n_exp && i < ncap; i++)
      chk(cap_code[i] == (byp ? sq[i] : gray(sq[i])), "R9 code value", cap_code[i], byp ? sq[i] : gray(sq[i]));
    for (int i = 1; i < ncap; i++)
      chk(cap_cyc[i] - cap_cyc[i-1] == p, "R5 tick spacing", cap_cyc[i] - cap_cyc[i-1], p);
    if (sm != 0 && ncap > 0) chk(cap_cyc[0] - t0 == p, "R4 first tick after start", cap_cyc[0] - t0, p);
    rd(2, v);
    chk(v[0] == done_exp, "R8 done flag", v[0], done_exp);
    chk(v[1] == uf_exp, "R10 underflow flag", v[1], uf_exp);
    if (sm != 0) chk(v[2] == ae_exp, "R11 almost-empty flag", v[2], ae_exp);
    chk(irq == (done_exp | uf_exp), "R11 irq", irq, done_exp | uf_exp);
    if (uf_exp && ncap > 0) chk(dac_code == cap_code[ncap-1], "R10 code held", dac_code, cap_code[ncap-1]);
    rd(0, v);
    chk(v[18] == !done_exp, "R12 active after run", v[18], !done_exp);
    chk(v[10:8] == 3'(ip), "R13 interp readback", v[10:8], ip);
    wr(0, ctl | 32'h8000_0000);
    wr(2, 32'h0003_0007);
    rd(2, v);
    chk(v == 32'h0003_0000, "R11 flags cleared", v, 32'h0003_0000);
    chk(irq == 1'b0, "R11 irq cleared", irq, 0);
    rd(0, v);
    chk(v[18] == 1'b0, "R12 soft reset stops", v[18], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, v); chk(v == 32'h0000_00C0, "R1 control reset", v, 32'hC0);
    rd(1, v); chk(v == 32'h0, "R1 rate reset", v, 0);
    rd(2, v); chk(v == 32'h0, "R1 interrupt reset", v, 0);
    rd(3, v); chk(v == 32'h0, "R1 level reset", v, 0);
    chk(dac_code == 16'h0 && !dac_strobe && !irq, "R1 outputs reset", {dac_code, dac_strobe, irq}, 0);

    // R3 threshold flags, start field 3 keeps the sequencer idle
    for (int it = 0; it < 8; it++) begin
      int aet, aft, n;
      aet = $urandom_range(0, 15); aft = $urandom_range(0, 15); n = $urandom_range(0, 16);
      wr(0, 32'h8003_0000 | 32'(aet) | (32'(aft) << 12));
      for (int i = 0; i < n; i++) wr(3, $urandom);
      rd(0, v);
      chk(v[6] == (n == 0), "R3 empty flag", v[6], n == 0);
      chk(v[7] == (n <= aet), "R3 almost-empty flag", v[7], n <= aet);
      chk(v[5] == (n > aft), "R3 almost-full flag", v[5], n > aft);
    end

    // R2 overfill and R4 reserved start field
    wr(0, 32'h8303_0000);
    for (int i = 0; i < 17; i++) begin sq[i] = 16'($urandom); wr(3, {16'h0, sq[i]}); end
    rd(3, v); chk(v == 32'd16, "R2 push when full ignored", v, 16);
    pulse_ext();
    wr(0, 32'h0313_0000);
    rd(0, v); chk(v[18] == 1'b0, "R4 reserved start never runs", v[18], 0);
    rd(3, v); chk(v == 32'd16, "R4 level untouched", v, 16);
    ncap = 0;
    wr(1, {16'd16, 16'd1});
    wr(0, 32'h0302_0000);
    wr(0, 32'h0312_0000);
    repeat (40) @(negedge clk);
    chk(ncap == 16, "R2 drained count", ncap, 16);
    for (int i = 0; i < 16; i++) chk(cap_code[i] == gray(sq[i]), "R2 order", cap_code[i], gray(sq[i]));

    // directed corners
    play(0, 0, 0, 3, 6, 0, 2, 9, 5);   // R6 auto start free-running, then underflow
    play(2, 0, 1, 4, 5, 0, 1, 3, 0);   // R6 reserved play mode
    play(3, 2, 0, 0, 8, 0, 3, 7, 7);   // R8 count 0 means one, R5 rate 0
    play(3, 1, 1, 2, 4, 6, 2, 1, 2);   // R10 counted run outlasts data
    play(1, 2, 0, 5, 3, 0, 2, 4, 1);   // R7 single sample

    for (int it = 0; it < 30; it++) begin
      int k;
      k = $urandom_range(1, 12);
      play($urandom_range(0, 1) ? 3 : 1, $urandom_range(1, 2), 1'($urandom), $urandom_range(0, 5),
           k, $urandom_range(0, k + 1), $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 7));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule